// File: doc/BRIEF.md
# Two-Cycle System Bus Master

This block sits between a processor core and a shared parallel system bus. The core hands it one request at a time over a valid/ready handshake. Each request carries an address, write data, a direction bit and an I/O flag. The master turns that request into a fixed two-clock bus transaction.

In the first bus cycle, called ADDR, the master places the address on the bus, plus the write data for a write. No strobe is active in ADDR, which gives the slaves a full clock to decode the address. In the second bus cycle, called STROBE, the read or write strobe is active. For a read, the master captures the bus data into a holding register at the end of STROBE. It then removes the address, the data and the strobe together. In the cycle after that, called FINISH, it returns the captured data with a single-cycle done pulse.

A parameter selects the I/O scheme:
- Isolated I/O: a separate select line tells the slaves whether the access targets memory or an I/O port. A memory location and an I/O port can therefore share the same address value.
- Memory-mapped I/O: the select line always carries the memory value.

A second parameter sets the strobe polarity to active-high or active-low.

The states are IDLE, ADDR, STROBE and FINISH. The transitions are:
- IDLE to ADDR when a request is accepted.
- ADDR to STROBE always.
- STROBE to FINISH always.
- FINISH to IDLE always.
- Any state to IDLE on synchronous reset.

Top module: `sysbus_master`

## Requirements
- R1: A synchronous reset, from any state, returns the block to IDLE. In IDLE `req_ready`=1, `rsp_done`=0, `bus_addr`=0, `bus_data_oe`=0 and `bus_io_sel`=0, and both strobes are at their inactive level.
- R2: In the cycle after a request is accepted (ADDR), `bus_addr` equals the request address and both strobes are inactive.
- R3: In the following cycle (STROBE), `bus_addr` keeps the same value. For a read the read strobe is active. The value on `bus_data_in` at the end of that cycle becomes `rsp_rdata`.
- R4: After STROBE, `bus_addr` returns to 0 and the read strobe returns to inactive in the same clock.
- R5: For a write, `bus_data_oe`=1 and `bus_data_out` equals the request data in both ADDR and STROBE. The write strobe is inactive in ADDR and active in STROBE.
- R6: After a write's STROBE cycle, `bus_addr`=0, `bus_data_oe`=0 and the write strobe is inactive.
- R7: `bus_data_oe` is 0 in every cycle that is not part of a write's ADDR or STROBE cycles, reads included.
- R8: With `ISOLATED_IO`=1, `bus_io_sel` equals the request's I/O flag during ADDR and STROBE and is 0 in all other cycles. The value 1 selects I/O and 0 selects memory.
- R9: With `ISOLATED_IO`=0, `bus_io_sel` is 0 in every cycle and the request's I/O flag has no effect.
- R10: With `STROBE_HIGH`=1 an active strobe is 1. With `STROBE_HIGH`=0 an active strobe is 0 and an inactive strobe is 1.
- R11: `req_ready` is 1 only in IDLE, and requests presented in other states are ignored. `rsp_done` is 1 for exactly one cycle (FINISH), the cycle after STROBE. `rsp_rdata` keeps its value until the next read completes.
- R12: The read and write strobes are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master is idle and can accept a request |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O access, 0 = memory access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data from the holding register |
| bus_addr | output | ADDR_W | System address bus, output only |
| bus_data_out | output | DATA_W | Data driven onto the system data bus |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_data_in | input | DATA_W | Data sampled from the system data bus |
| bus_rd | output | 1 | Read strobe, polarity set by STROBE_HIGH |
| bus_wr | output | 1 | Write strobe, polarity set by STROBE_HIGH |
| bus_io_sel | output | 1 | 1 = I/O space, 0 = memory space |

## Verification
The bench builds two copies of the block side by side and drives them with the same request stream. The first uses isolated I/O with active-high strobes. The second uses memory-mapped I/O with active-low strobes. Between them, both generate branches and both strobe polarities are exercised in every transaction. Reads to the same address with the I/O flag set and cleared return different values on the isolated copy and the memory value on the mapped copy. This shows directly that the select line separates the two spaces only where it should.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_STROBE = 2'd2,
        ST_FINISH = 2'd3
    } bus_state_e;
endpackage

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
    import sysbus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic op_write,
    output logic ready,
    output logic accept,
    output logic drive,
    output logic rd_act,
    output logic wr_act,
    output logic capture,
    output logic done
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_STROBE;
            ST_STROBE: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready   = 1'b0;
        drive   = 1'b0;
        rd_act  = 1'b0;
        wr_act  = 1'b0;
        capture = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ready = 1'b1;
            ST_ADDR:   drive = 1'b1;
            ST_STROBE: begin
                drive   = 1'b1;
                rd_act  = !op_write;
                wr_act  = op_write;
                capture = !op_write;
            end
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign accept = ready && req_valid;

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_ready_not_busy_r11: assert property (@(posedge clk) disable iff (rst)
        ready |-> !drive && !done);
    p_no_strobe_first_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(drive) |-> !rd_act && !wr_act);
    p_done_after_drive_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(drive));
endmodule

// File: rtl/sysbus_path.sv
module sysbus_path #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter bit ISOLATED_IO = 1'b1,
    parameter bit STROBE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              drive,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              op_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    output logic              bus_io_sel,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] hold_q;
    logic              write_q;
    logic              io_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (capture) hold_q <= bus_data_in;
    end

    generate
        if (ISOLATED_IO) begin : g_isolated
            always_ff @(posedge clk) begin
                if (rst)         io_q <= 1'b0;
                else if (accept) io_q <= req_io;
            end
        end else begin : g_mapped
            assign io_q = 1'b0;
            p_io_mem_r9: assert property (@(posedge clk) disable iff (rst)
                !bus_io_sel);
        end
    endgenerate

    generate
        if (STROBE_HIGH) begin : g_act_high
            assign bus_rd = rd_act;
            assign bus_wr = wr_act;
        end else begin : g_act_low
            assign bus_rd = !rd_act;
            assign bus_wr = !wr_act;
        end
    endgenerate

    always_comb begin
        bus_addr     = drive ? addr_q : '0;
        bus_data_oe  = drive && write_q;
        bus_data_out = (drive && write_q) ? wdata_q : '0;
        bus_io_sel   = drive && io_q;
    end

    assign op_write  = write_q;
    assign rsp_rdata = hold_q;

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !((bus_rd == STROBE_HIGH) && (bus_wr == STROBE_HIGH)));
    p_no_oe_on_read_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd == STROBE_HIGH) |-> !bus_data_oe);
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd == STROBE_HIGH || bus_wr == STROBE_HIGH) |-> $stable(bus_addr));
    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(drive) |-> bus_addr == '0 && !bus_data_oe && !bus_io_sel);
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter bit ISOLATED_IO = 1'b1,
    parameter bit STROBE_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_io_sel
);
    logic accept, drive, rd_act, wr_act, capture, op_write;

    sysbus_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .op_write  (op_write),
        .ready     (req_ready),
        .accept    (accept),
        .drive     (drive),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .capture   (capture),
        .done      (rsp_done)
    );

    sysbus_path #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ISOLATED_IO (ISOLATED_IO),
        .STROBE_HIGH (STROBE_HIGH)
    ) u_path (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .drive        (drive),
        .rd_act       (rd_act),
        .wr_act       (wr_act),
        .capture      (capture),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_write    (req_write),
        .req_io       (req_io),
        .bus_data_in  (bus_data_in),
        .op_write     (op_write),
        .bus_addr     (bus_addr),
        .bus_data_out (bus_data_out),
        .bus_data_oe  (bus_data_oe),
        .bus_io_sel   (bus_io_sel),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .rsp_rdata    (rsp_rdata)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> bus_addr == '0 && !bus_data_oe && bus_rd != STROBE_HIGH
                      && bus_wr != STROBE_HIGH && !rsp_done);
endmodule

// File: tb/sysbus_master_tb.sv
module sysbus_master_tb;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_write = 1'b0;
    logic req_io = 1'b0;

    logic ready_a, done_a, oe_a, rd_a, wr_a, io_a;
    logic [DW-1:0] rdata_a, dout_a, din_a;
    logic [AW-1:0] addr_a;
    logic ready_b, done_b, oe_b, rd_b, wr_b, io_b;
    logic [DW-1:0] rdata_b, dout_b, din_b;
    logic [AW-1:0] addr_b;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] last_a = '0;
    logic [DW-1:0] last_b = '0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] slave_model(input logic [AW-1:0] a, input logic io);
        return a[7:0] ^ a[15:8] ^ (io ? 8'h96 : 8'h3C);
    endfunction

    assign din_a = slave_model(addr_a, io_a);
    assign din_b = slave_model(addr_b, io_b);

    // Isolated I/O, active-high strobes
    sysbus_master #(.ADDR_W(AW), .DATA_W(DW), .ISOLATED_IO(1'b1), .STROBE_HIGH(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready_a),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .rsp_done(done_a), .rsp_rdata(rdata_a), .bus_addr(addr_a), .bus_data_out(dout_a),
        .bus_data_oe(oe_a), .bus_data_in(din_a), .bus_rd(rd_a), .bus_wr(wr_a), .bus_io_sel(io_a));

    // Memory-mapped I/O, active-low strobes
    sysbus_master #(.ADDR_W(AW), .DATA_W(DW), .ISOLATED_IO(1'b0), .STROBE_HIGH(1'b0)) u_dut_mm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(ready_b),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .rsp_done(done_b), .rsp_rdata(rdata_b), .bus_addr(addr_b), .bus_data_out(dout_b),
        .bus_data_oe(oe_b), .bus_data_in(din_b), .bus_rd(rd_b), .bus_wr(wr_b), .bus_io_sel(io_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Strobe levels: copy A is active-high, copy B is active-low (R10)
    task automatic chk_strobes(input string req, input logic rd_on, input logic wr_on);
        chk({req, " rd A"}, rd_a, rd_on);
        chk({req, " wr A"}, wr_a, wr_on);
        chk({req, " rd B R10"}, rd_b, !rd_on);
        chk({req, " wr B R10"}, wr_b, !wr_on);
    endtask

    task automatic chk_idle(input string req);
        chk({req, " ready A"}, ready_a, 1'b1);
        chk({req, " ready B"}, ready_b, 1'b1);
        chk({req, " done A"}, done_a, 1'b0);
        chk({req, " done B"}, done_b, 1'b0);
        chk({req, " addr A"}, addr_a, 0);
        chk({req, " addr B"}, addr_b, 0);
        chk({req, " oe A R7"}, oe_a, 1'b0);
        chk({req, " oe B R7"}, oe_b, 1'b0);
        chk({req, " io A R8"}, io_a, 1'b0);
        chk({req, " io B R9"}, io_b, 1'b0);
        chk_strobes(req, 1'b0, 1'b0);
    endtask

    task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic w, input logic io, input bit hammer);
        logic [DW-1:0] exp_a, exp_b;
        exp_a = w ? last_a : slave_model(a, io);
        exp_b = w ? last_b : slave_model(a, 1'b0);
        @(negedge clk);
        chk_idle("R1 R11 idle before request");
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = w; req_io = io;
        @(negedge clk); // ADDR
        chk("R2 addr A", addr_a, a);
        chk("R2 addr B", addr_b, a);
        chk_strobes("R2 first cycle", 1'b0, 1'b0);
        chk("R5 R7 oe A", oe_a, w);
        chk("R5 R7 oe B", oe_b, w);
        if (w) begin
            chk("R5 wdata A", dout_a, d);
            chk("R5 wdata B", dout_b, d);
        end
        chk("R8 io A", io_a, io);
        chk("R9 io B", io_b, 1'b0);
        chk("R11 ready A busy", ready_a, 1'b0);
        if (hammer) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~w; req_io = ~io;
        end else req_valid = 1'b0;
        @(negedge clk); // STROBE
        chk("R3 addr held A", addr_a, a);
        chk("R3 addr held B R11", addr_b, a);
        chk_strobes(w ? "R5 second cycle" : "R3 second cycle", !w, w);
        chk("R5 R7 oe A", oe_a, w);
        if (w) chk("R5 wdata A", dout_a, d);
        chk("R8 io A", io_a, io);
        chk("R9 io B", io_b, 1'b0);
        chk("R11 done A early", done_a, 1'b0);
        req_valid = 1'b0;
        @(negedge clk); // FINISH
        chk("R11 done A", done_a, 1'b1);
        chk("R11 done B", done_b, 1'b1);
        chk("R11 ready A finish", ready_a, 1'b0);
        chk(w ? "R6 addr A" : "R4 addr A", addr_a, 0);
        chk(w ? "R6 addr B" : "R4 addr B", addr_b, 0);
        chk(w ? "R6 oe A" : "R7 oe A", oe_a, 1'b0);
        chk_strobes(w ? "R6 release" : "R4 release", 1'b0, 1'b0);
        chk("R8 io A released", io_a, 1'b0);
        chk("R3 rdata A", rdata_a, exp_a);
        chk("R3 R9 rdata B", rdata_b, exp_b);
        @(negedge clk); // IDLE again
        chk("R11 done single A", done_a, 1'b0);
        chk("R11 rdata hold A", rdata_a, exp_a);
        chk("R11 rdata hold B", rdata_b, exp_b);
        last_a = exp_a;
        last_b = exp_b;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk_idle("R1 reset state");
        chk("R1 rdata A", rdata_a, 0);
        rst = 1'b0;

        // Directed corners
        run_txn(16'h0000, 8'h00, 1'b0, 1'b0, 1'b0);
        run_txn(16'hFFFF, 8'hFF, 1'b1, 1'b1, 1'b0);
        run_txn(16'h1234, 8'h00, 1'b0, 1'b1, 1'b0);  // R8 same address, I/O space
        run_txn(16'h1234, 8'h00, 1'b0, 1'b0, 1'b0);  // R8 same address, memory space
        run_txn(16'h00A5, 8'h5A, 1'b1, 1'b0, 1'b1);  // R11 request held while busy
        run_txn(16'hC003, 8'h00, 1'b0, 1'b1, 1'b1);

        // R1 reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h4321; req_write = 1'b0; req_io = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk); // STROBE
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R1 mid-transaction reset");
        chk("R1 rdata cleared A", rdata_a, 0);
        rst = 1'b0;
        last_a = '0;
        last_b = '0;

        for (int i = 0; i < 300; i++) begin
            run_txn(AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule